// File: doc/BRIEF.md
# Soft-Sectored Track Format Sequencer

This block lays down the complete byte image of one soft-sectored track while a fixed disk is formatted. Once it is armed, it waits for the next index pulse. It then streams gap fill, sync runs, identification fields and data fields for each sector, in order, toward a downstream MFM encoder. Writing continues until the following index pulse. A mark flag travels with the stream and tells the encoder which bytes are address-mark lead bytes. The encoder writes those bytes with a missing clock bit.

The encoder paces the stream with a byte strobe. On each strobe it takes the byte on the output, and the sequencer moves to the next byte. The host supplies the cylinder, head, number of sectors and the byte used to fill data fields. The sequencer computes the 16-bit CRC that closes every identification field and every data field. If the closing index pulse arrives before every sector is written, the pass ends with an overflow error.

Top module: `trk_fmt_seq`

## Requirements
- R1: After reset, valid_o, wgate_o, mark_o, done_o and ovf_o are all low.
- R2: A start_i pulse in the idle or done state arms the block. valid_o and wgate_o stay low until the first rising edge of index_i after arming, and the first byte after that edge is the first Gap 1 byte.
- R3: The track opens with GAP1_LEN bytes of 4E hex. Sectors 0 to sect_cnt_i-1 then follow in ascending order. Each sector is built as: sync, ID field, ID CRC, Gap 2, sync, data field, data CRC, Gap 3. Valid values of sect_cnt_i are 1 to SECTORS.
- R4: Each ID field holds seven bytes in this order: A1, FE, cylinder high byte, cylinder low byte, head zero-extended to 8 bits, sector number, and the length code 01.
- R5: Each data field holds A1, then F8, then DATA_BYTES copies of fill_i.
- R6: Every ID field and every data field is followed by two CRC bytes, high byte first. The CRC uses the polynomial x^16+x^12+x^5+1 and is preset to FFFF. It covers the field from its A1 byte through its last byte.
- R7: Every sync run is SYNC_LEN bytes of 00. Gap 2 is GAP2_LEN bytes of 4E, and Gap 3 is GAP3_LEN bytes of 4E.
- R8: After the last sector's Gap 3, the block sends 4E until the next index rising edge. At that edge wgate_o and valid_o drop, done_o rises, and ovf_o stays low.
- R9: An index rising edge that arrives before the last Gap 3 byte has been taken ends the pass with done_o and ovf_o both high.
- R10: While running, byte_o advances by exactly one byte on each clock with byte_tick_i high. It holds its value on every clock with byte_tick_i low.
- R11: mark_o is high only while valid_o is high and byte_o is the A1 lead byte of an address mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a format pass |
| index_i | input | 1 | Index pulse from the drive |
| byte_tick_i | input | 1 | Encoder takes the current byte |
| sect_cnt_i | input | $clog2(SECTORS+1) | Number of sectors to write |
| cyl_i | input | 16 | Cylinder number |
| head_i | input | HEAD_W | Head number |
| fill_i | input | 8 | Data field fill byte |
| byte_o | output | 8 | Current track byte |
| valid_o | output | 1 | byte_o is part of the track |
| mark_o | output | 1 | Address-mark lead byte, clock to be omitted |
| wgate_o | output | 1 | Write gate |
| done_o | output | 1 | Pass finished |
| ovf_o | output | 1 | Pass ended before all sectors were written |

## Verification
The bench generates the full expected track image with its own bit-serial CRC for several sector counts, cylinders, heads and fill bytes. It then compares every byte and mark bit. A design with wrong CRC coverage or preset fails on the first CRC byte. A design with an off-by-one field length shifts every byte that follows.

One pass withholds the strobe on every third clock. A design that advances without a strobe, or drops bytes, fails there. The index pulse is placed exactly at the start of Gap 4 and also one byte earlier. This separates a clean finish from an overflow, so a design that tests the wrong boundary gets the flag wrong. Strobes sent while the block is armed but before the index edge must produce no write.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic [3:0] {
    FLD_GAP1, FLD_SYNC_ID, FLD_ID, FLD_ID_CRC, FLD_GAP2,
    FLD_SYNC_DAT, FLD_DAT, FLD_DAT_CRC, FLD_GAP3, FLD_GAP4
  } fld_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_DONE} st_e;

  localparam logic [7:0] GAP_BYTE  = 8'h4E;
  localparam logic [7:0] SYNC_BYTE = 8'h00;
  localparam logic [7:0] AM_LEAD   = 8'hA1;
  localparam logic [7:0] AM_ID     = 8'hFE;
  localparam logic [7:0] AM_DAT    = 8'hF8;
  localparam logic [7:0] LEN_CODE  = 8'h01;
  localparam int ID_BODY_LEN = 7;
  localparam int AM_LEN      = 2;
  localparam int CRC_LEN     = 2;
endpackage

// File: rtl/fmt_crc16.sv
module fmt_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        preset_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q ^ {data_i, 8'h00};
    for (int b = 0; b < 8; b++)
      crc_nxt = crc_nxt[15] ? ((crc_nxt << 1) ^ POLY) : (crc_nxt << 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= INIT;
    else if (preset_i) crc_q <= INIT;
    else if (upd_i)    crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
  import fmt_pkg::*;
#(
  parameter int SECTORS    = 32,
  parameter int DATA_BYTES = 256,
  parameter int GAP1_LEN   = 11,
  parameter int GAP2_LEN   = 3,
  parameter int GAP3_LEN   = 15,
  parameter int SYNC_LEN   = 12,
  parameter int CNT_W      = 9,
  parameter int SEC_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [SEC_W-1:0] sect_cnt_i,
  output fld_e             field_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [SEC_W-1:0] sec_o
);
  fld_e             field_q;
  logic [CNT_W-1:0] idx_q, len;
  logic [SEC_W-1:0] sec_q;
  logic             last;

  always_comb begin
    unique case (field_q)
      FLD_GAP1:                  len = CNT_W'(GAP1_LEN);
      FLD_SYNC_ID, FLD_SYNC_DAT: len = CNT_W'(SYNC_LEN);
      FLD_ID:                    len = CNT_W'(ID_BODY_LEN);
      FLD_ID_CRC, FLD_DAT_CRC:   len = CNT_W'(CRC_LEN);
      FLD_GAP2:                  len = CNT_W'(GAP2_LEN);
      FLD_DAT:                   len = CNT_W'(DATA_BYTES + AM_LEN);
      FLD_GAP3:                  len = CNT_W'(GAP3_LEN);
      default:                   len = '1;
    endcase
  end

  assign last = (idx_q == len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= FLD_GAP1;
      idx_q   <= '0;
      sec_q   <= '0;
    end else if (clear_i) begin
      field_q <= FLD_GAP1;
      idx_q   <= '0;
      sec_q   <= '0;
    end else if (adv_i && field_q != FLD_GAP4) begin
      if (!last) begin
        idx_q <= idx_q + CNT_W'(1);
      end else begin
        idx_q <= '0;
        unique case (field_q)
          FLD_GAP1:     field_q <= FLD_SYNC_ID;
          FLD_SYNC_ID:  field_q <= FLD_ID;
          FLD_ID:       field_q <= FLD_ID_CRC;
          FLD_ID_CRC:   field_q <= FLD_GAP2;
          FLD_GAP2:     field_q <= FLD_SYNC_DAT;
          FLD_SYNC_DAT: field_q <= FLD_DAT;
          FLD_DAT:      field_q <= FLD_DAT_CRC;
          FLD_DAT_CRC:  field_q <= FLD_GAP3;
          FLD_GAP3: begin
            if (sec_q == sect_cnt_i - SEC_W'(1)) begin
              field_q <= FLD_GAP4;
            end else begin
              field_q <= FLD_SYNC_ID;
              sec_q   <= sec_q + SEC_W'(1);
            end
          end
          default:      field_q <= field_q;
        endcase
      end
    end
  end

  assign field_o = field_q;
  assign idx_o   = idx_q;
  assign sec_o   = sec_q;

  a_r3_idx_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_q != FLD_GAP4) |-> (idx_q < len));

  a_r8_gap4_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_q == FLD_GAP4 && !clear_i) |=> (field_q == FLD_GAP4));
endmodule

// File: rtl/fmt_byte_mux.sv
module fmt_byte_mux
  import fmt_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int SEC_W  = 6,
  parameter int HEAD_W = 4
) (
  input  fld_e              field_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [15:0]       cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [7:0]        fill_i,
  input  logic [15:0]       crc_i,
  output logic [7:0]        byte_o,
  output logic              mark_o
);
  logic first;
  assign first = (idx_i == '0);

  always_comb begin
    byte_o = GAP_BYTE;
    mark_o = 1'b0;
    unique case (field_i)
      FLD_SYNC_ID, FLD_SYNC_DAT: byte_o = SYNC_BYTE;
      FLD_ID: begin
        unique case (idx_i)
          CNT_W'(0): begin byte_o = AM_LEAD; mark_o = 1'b1; end
          CNT_W'(1): byte_o = AM_ID;
          CNT_W'(2): byte_o = cyl_i[15:8];
          CNT_W'(3): byte_o = cyl_i[7:0];
          CNT_W'(4): byte_o = 8'(head_i);
          CNT_W'(5): byte_o = 8'(sec_i);
          default:   byte_o = LEN_CODE;
        endcase
      end
      FLD_DAT: begin
        if (first) begin
          byte_o = AM_LEAD;
          mark_o = 1'b1;
        end else if (idx_i == CNT_W'(1)) begin
          byte_o = AM_DAT;
        end else begin
          byte_o = fill_i;
        end
      end
      FLD_ID_CRC, FLD_DAT_CRC: byte_o = first ? crc_i[15:8] : crc_i[7:0];
      default: byte_o = GAP_BYTE;
    endcase
  end
endmodule

// File: rtl/trk_fmt_seq.sv
module trk_fmt_seq
  import fmt_pkg::*;
#(
  parameter int SECTORS    = 32,
  parameter int DATA_BYTES = 256,
  parameter int GAP1_LEN   = 11,
  parameter int GAP2_LEN   = 3,
  parameter int GAP3_LEN   = 15,
  parameter int SYNC_LEN   = 12,
  parameter int HEAD_W     = 4,
  localparam int SEC_W     = $clog2(SECTORS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              index_i,
  input  logic              byte_tick_i,
  input  logic [SEC_W-1:0]  sect_cnt_i,
  input  logic [15:0]       cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [7:0]        fill_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              mark_o,
  output logic              wgate_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam int LEN_SUM = GAP1_LEN + GAP2_LEN + GAP3_LEN + SYNC_LEN + DATA_BYTES + 2 * AM_LEN + ID_BODY_LEN;
  localparam int CNT_W   = $clog2(LEN_SUM + 1);

  st_e              st_q;
  logic             index_q, idx_rise, running, accept, adv, ovf_q;
  fld_e             field;
  logic [CNT_W-1:0] idx;
  logic [SEC_W-1:0] sec;
  logic [15:0]      crc;
  logic [7:0]       mux_byte;
  logic             mux_mark;

  assign idx_rise = index_i & ~index_q;
  assign running  = (st_q == ST_RUN);
  assign accept   = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign adv      = running && byte_tick_i && !idx_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      index_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      index_q <= index_i;
      if (accept) begin
        st_q  <= ST_ARM;
        ovf_q <= 1'b0;
      end else if (st_q == ST_ARM && idx_rise) begin
        st_q <= ST_RUN;
      end else if (running && idx_rise) begin
        st_q  <= ST_DONE;
        ovf_q <= (field != FLD_GAP4);
      end
    end
  end

  fmt_seq #(
    .SECTORS(SECTORS), .DATA_BYTES(DATA_BYTES), .GAP1_LEN(GAP1_LEN),
    .GAP2_LEN(GAP2_LEN), .GAP3_LEN(GAP3_LEN), .SYNC_LEN(SYNC_LEN),
    .CNT_W(CNT_W), .SEC_W(SEC_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .adv_i(adv),
    .sect_cnt_i(sect_cnt_i), .field_o(field), .idx_o(idx), .sec_o(sec)
  );

  fmt_crc16 u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .preset_i(field == FLD_SYNC_ID || field == FLD_SYNC_DAT),
    .upd_i(adv && (field == FLD_ID || field == FLD_DAT)),
    .data_i(mux_byte), .crc_o(crc)
  );

  fmt_byte_mux #(.CNT_W(CNT_W), .SEC_W(SEC_W), .HEAD_W(HEAD_W)) u_mux (
    .field_i(field), .idx_i(idx), .sec_i(sec), .cyl_i(cyl_i), .head_i(head_i),
    .fill_i(fill_i), .crc_i(crc), .byte_o(mux_byte), .mark_o(mux_mark)
  );

  assign byte_o  = running ? mux_byte : 8'h00;
  assign mark_o  = running && mux_mark;
  assign valid_o = running;
  assign wgate_o = running;
  assign done_o  = (st_q == ST_DONE);
  assign ovf_o   = ovf_q;

  a_r2_write_after_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wgate_o) |-> $past(index_i));

  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !byte_tick_i && !idx_rise) |=>
      ($stable(byte_o) || !$stable(fill_i) || !$stable(cyl_i) || !$stable(head_i)));

  a_r11_mark_on_a1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> (valid_o && byte_o == AM_LEAD));

  a_r9_ovf_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> done_o);

  a_r8_done_gate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wgate_o);
endmodule

// File: tb/tb_trk_fmt_seq.sv
`timescale 1ns/1ps
module tb_trk_fmt_seq;
  localparam int SECT = 4, DATA = 6, G1 = 11, G2 = 3, G3 = 15, SY = 12, HW = 4;
  localparam int SW = $clog2(SECT + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, index_i = 0, tick_i = 0;
  logic [SW-1:0] cnt_i = '0;
  logic [15:0] cyl_i = '0;
  logic [HW-1:0] head_i = '0;
  logic [7:0] fill_i = '0;
  logic [7:0] byte_o;
  logic valid_o, mark_o, wgate_o, done_o, ovf_o;

  always #2 clk = ~clk;

  trk_fmt_seq #(.SECTORS(SECT), .DATA_BYTES(DATA), .GAP1_LEN(G1), .GAP2_LEN(G2),
                .GAP3_LEN(G3), .SYNC_LEN(SY), .HEAD_W(HW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .index_i(index_i),
    .byte_tick_i(tick_i), .sect_cnt_i(cnt_i), .cyl_i(cyl_i), .head_i(head_i),
    .fill_i(fill_i), .byte_o(byte_o), .valid_o(valid_o), .mark_o(mark_o),
    .wgate_o(wgate_o), .done_o(done_o), .ovf_o(ovf_o));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_b [0:511];
  bit exp_m [0:511];
  int exp_n;
  logic [15:0] tcrc;

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit m, input bit cov);
    exp_b[exp_n] = b;
    exp_m[exp_n] = m;
    if (cov) tcrc = crc_bit(tcrc, b);
    exp_n++;
  endtask

  task automatic build(input int cnt, input logic [15:0] cyl, input logic [HW-1:0] hd,
                       input logic [7:0] fill);
    logic [15:0] c;
    exp_n = 0;
    for (int i = 0; i < G1; i++) push(8'h4E, 0, 0);
    for (int s = 0; s < cnt; s++) begin
      for (int i = 0; i < SY; i++) push(8'h00, 0, 0);
      tcrc = 16'hFFFF;
      push(8'hA1, 1, 1); push(8'hFE, 0, 1);
      push(cyl[15:8], 0, 1); push(cyl[7:0], 0, 1);
      push(8'(hd), 0, 1); push(8'(s), 0, 1); push(8'h01, 0, 1);
      c = tcrc; push(c[15:8], 0, 0); push(c[7:0], 0, 0);
      for (int i = 0; i < G2; i++) push(8'h4E, 0, 0);
      for (int i = 0; i < SY; i++) push(8'h00, 0, 0);
      tcrc = 16'hFFFF;
      push(8'hA1, 1, 1); push(8'hF8, 0, 1);
      for (int i = 0; i < DATA; i++) push(fill, 0, 1);
      c = tcrc; push(c[15:8], 0, 0); push(c[7:0], 0, 0);
      for (int i = 0; i < G3; i++) push(8'h4E, 0, 0);
    end
  endtask

  task automatic run_track(input int cnt, input logic [15:0] cyl, input logic [HW-1:0] hd,
                           input logic [7:0] fill, input int n_ticks, input int gap_every);
    int k = 0, cyc = 0;
    bit t;
    logic [7:0] e;
    bit em;
    build(cnt, cyl, hd, fill);
    cnt_i = SW'(cnt); cyl_i = cyl; head_i = hd; fill_i = fill;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < 4; i++) begin
      tick_i = 1;
      check(!valid_o && !wgate_o && !done_o, "R2 idle before index", valid_o, 0);
      @(negedge clk);
    end
    tick_i = 0; index_i = 1;
    @(negedge clk); index_i = 0;
    while (k < n_ticks) begin
      t = !(gap_every != 0 && (cyc % gap_every) == gap_every - 1);
      tick_i = t;
      e  = (k < exp_n) ? exp_b[k] : 8'h4E;
      em = (k < exp_n) ? exp_m[k] : 1'b0;
      if (!t)
        check(valid_o && byte_o == e && mark_o == em, "R10 hold without tick", byte_o, e);
      else if (k == 0)
        check(valid_o && wgate_o && byte_o == e && mark_o == em, "R2 first byte", byte_o, e);
      else if (k < exp_n)
        check(valid_o && byte_o == e && mark_o == em,
              $sformatf("R3 R4 R5 R6 R7 R11 byte %0d", k), {mark_o, byte_o}, {em, e});
      else
        check(valid_o && byte_o == e && mark_o == em, "R8 gap4 fill", byte_o, e);
      if (t) k++;
      cyc++;
      @(negedge clk);
    end
    tick_i = 0; index_i = 1;
    @(negedge clk); index_i = 0;
    if (n_ticks < exp_n)
      check(done_o && ovf_o && !valid_o && !wgate_o, "R9 overflow end", {done_o, ovf_o}, 2'b11);
    else
      check(done_o && !ovf_o && !valid_o && !wgate_o, "R8 clean end", {done_o, ovf_o}, 2'b10);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #10;
    check(!valid_o && !wgate_o && !mark_o && !done_o && !ovf_o, "R1 reset outputs",
          {valid_o, wgate_o, mark_o, done_o, ovf_o}, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    check(!valid_o && !done_o, "R1 idle after reset", valid_o, 0);
    run_track(4, 16'h1234, 4'd3, 8'hE5, 300, 0);
    run_track(2, 16'h00FF, 4'd15, 8'h00, 150, 3);
    run_track(4, 16'h8001, 4'd0, 8'h6C, 100, 0);
    run_track(1, 16'h0203, 4'd7, 8'hFF, 72, 0);
    run_track(4, 16'hFFFF, 4'd9, 8'h4E, 254, 0);
    run_track(4, 16'hFFFF, 4'd9, 8'h4E, 255, 4);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule